// File: doc/BRIEF.md
# Digital Rate-Trim Divider for a 32 kHz Timebase

This block turns a 32,768 Hz enable stream into a one-pulse-per-second tick and trims its long-term rate without any analog tuning. It counts in two stages: a first stage divides by 256 and a second stage divides the result down to one second. To correct a crystal that runs fast or slow, the block changes the length of selected seconds by a fixed number of oscillator counts. A positive setting shortens the chosen second by one full first-stage period (256 counts), which speeds the clock up. A negative setting lengthens it by half a first-stage period (128 counts), which slows the clock down.

Minutes and a 64-minute correction cycle are tracked inside the block. With a magnitude N from 0 to 31, the first second of each of the first 2N minutes of the cycle is the one that gets modified, so at most 62 minutes per cycle are touched. Each step of the setting is worth about +4.07 ppm when positive and about -2.03 ppm when negative. A 512 Hz square wave taken from the first stage lets the raw oscillator error be measured. A reading of 512.01 Hz, for example, shows +20 ppm and calls for a negative setting of 10. A stop input freezes every counter, and the setting is sampled once per minute.

Top module: `osc_trim_divider`

## Requirements
- R1: After a synchronous reset, `sec_tick` and `test_out` are 0. The second, minute and cycle positions restart at zero, and the applied setting is loaded from the live `cal_mag`/`cal_pos` inputs during reset.
- R2: An unmodified second lasts exactly PRE_DIV*POST_DIV advancing ticks. An advancing tick is a clock with `osc_en`=1 and `stop`=0.
- R3: With `cal_pos`=1 and magnitude N>0, the first second (index 0) of each minute whose index in the cycle is below 2N lasts PRE_DIV fewer advancing ticks.
- R4: With `cal_pos`=0 and magnitude N>0, that same second lasts PRE_DIV/2 more advancing ticks.
- R5: Seconds with index 1 to SEC_PER_MIN-1, all seconds of minutes with index 2N or higher, and all seconds when N=0 keep the nominal length.
- R6: The minute index counts 0 to MIN_PER_CYCLE-1 and then wraps to 0, so corrections repeat in every cycle.
- R7: The setting is sampled only when a minute ends, using the input values at that clock, and applies from the next minute on. A change in the middle of a minute does not alter the rest of that minute.
- R8: `test_out` is a square wave that changes level once every TEST_DIV/2 advancing ticks, whatever correction is in force, and changes only on advancing ticks.
- R9: While `stop`=1, no counter advances, `sec_tick` stays 0 and `test_out` holds its level, even when `osc_en` is 1.
- R10: `sec_tick` is high for one clock, in the clock after the advancing tick that ends a second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One oscillator count (32,768 Hz rate) when high |
| stop | input | 1 | Freezes the whole divider while high |
| cal_mag | input | 5 | Correction magnitude N, 0 to 31 |
| cal_pos | input | 1 | 1: shorten seconds (speed up); 0: lengthen (slow down) |
| sec_tick | output | 1 | One-clock pulse per corrected second |
| test_out | output | 1 | Square wave at oscillator rate / TEST_DIV |

## Verification
The bench builds the divider with PRE_DIV=8, POST_DIV=4, SEC_PER_MIN=3, TEST_DIV=4, and keeps MIN_PER_CYCLE=64 and the full 5-bit magnitude. A nominal second is then 32 ticks, a shortened one 24 and a lengthened one 36. A whole 64-minute cycle takes only about 6,000 ticks. This puts the widest window (N=31, minutes 62 and 63 left untouched), the cycle wrap, mid-minute setting changes and repeated cycles with both signs all within a short run.

// File: rtl/trim_div_pkg.sv
package trim_div_pkg;

    localparam int TRIM_MAG_W = 5;

    typedef struct packed {
        logic                  pos;
        logic [TRIM_MAG_W-1:0] mag;
    } trim_set_t;

    typedef enum logic [1:0] {
        SEC_PLAIN = 2'd0,
        SEC_SHORT = 2'd1,
        SEC_LONG  = 2'd2
    } sec_kind_t;

    // Which kind of second the divider is producing right now
    function automatic sec_kind_t pick_kind(input int sec_idx, input int min_idx,
                                            input trim_set_t s);
        if (sec_idx == 0 && min_idx < 2 * int'(s.mag))
            return s.pos ? SEC_SHORT : SEC_LONG;
        return SEC_PLAIN;
    endfunction

endpackage

// File: rtl/trim_stage_div.sv
module trim_stage_div #(
    parameter int PRE_DIV  = 256,
    parameter int TEST_DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic stretch,
    output logic stage_end,
    output logic test_wave
);
    localparam int EXT     = PRE_DIV / 2;
    localparam int CNT_TOP = PRE_DIV + EXT - 1;
    localparam int CW      = $clog2(CNT_TOP + 1);
    localparam int TBIT    = $clog2(TEST_DIV) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // A stretched period runs on for half a period more
    assign limit     = stretch ? CW'(CNT_TOP) : CW'(PRE_DIV - 1);
    assign stage_end = adv && (cnt == limit);
    assign test_wave = cnt[TBIT];

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (adv)
            cnt <= stage_end ? '0 : cnt + 1'b1;
    end

    assert_base_span_R2: assert property (@(posedge clk) disable iff (rst)
        !stretch |-> (cnt <= CW'(PRE_DIV - 1)));

    assert_stage_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));

endmodule

// File: rtl/trim_sec_div.sv
module trim_sec_div
    import trim_div_pkg::*;
#(
    parameter int POST_DIV = 128
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      stage_end,
    input  sec_kind_t kind,
    output logic      stretch,
    output logic      sec_end
);
    localparam int SW = $clog2(POST_DIV);

    logic [SW-1:0] cnt;
    logic [SW-1:0] last;
    logic          at_last;

    // A shortened second drops its final stage period
    assign last    = (kind == SEC_SHORT) ? SW'(POST_DIV - 2) : SW'(POST_DIV - 1);
    assign at_last = (cnt == last);
    assign sec_end = stage_end && at_last;
    assign stretch = (kind == SEC_LONG) && at_last;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (stage_end)
            cnt <= at_last ? '0 : cnt + 1'b1;
    end

    assert_short_span_R3: assert property (@(posedge clk) disable iff (rst)
        (kind == SEC_SHORT) |-> (cnt <= SW'(POST_DIV - 2)));

    assert_sec_restart_R2: assert property (@(posedge clk) disable iff (rst)
        sec_end |=> (cnt == '0));

endmodule

// File: rtl/trim_cycle_track.sv
module trim_cycle_track
    import trim_div_pkg::*;
#(
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_end,
    input  trim_set_t live,
    output sec_kind_t kind
);
    localparam int SCW = $clog2(SEC_PER_MIN);
    localparam int MCW = $clog2(MIN_PER_CYCLE);

    logic [SCW-1:0] sec_cnt;
    logic [MCW-1:0] min_cnt;
    trim_set_t      act;
    logic           min_end;

    assign min_end = sec_end && (sec_cnt == SCW'(SEC_PER_MIN - 1));
    assign kind    = pick_kind(int'(sec_cnt), int'(min_cnt), act);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_cnt <= '0;
            min_cnt <= '0;
            act     <= live;
        end else if (min_end) begin
            sec_cnt <= '0;
            act     <= live;
            min_cnt <= (min_cnt == MCW'(MIN_PER_CYCLE - 1)) ? '0 : min_cnt + 1'b1;
        end else if (sec_end) begin
            sec_cnt <= sec_cnt + 1'b1;
        end
    end

    assert_cycle_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (min_end && min_cnt == MCW'(MIN_PER_CYCLE - 1)) |=> (min_cnt == '0));

    assert_setting_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !min_end |=> $stable(act));

    assert_first_sec_only_R5: assert property (@(posedge clk) disable iff (rst)
        (kind != SEC_PLAIN) |-> (sec_cnt == '0));

endmodule

// File: rtl/osc_trim_divider.sv
module osc_trim_divider
    import trim_div_pkg::*;
#(
    parameter int PRE_DIV       = 256,
    parameter int POST_DIV      = 128,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    parameter int TEST_DIV      = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  osc_en,
    input  logic                  stop,
    input  logic [TRIM_MAG_W-1:0] cal_mag,
    input  logic                  cal_pos,
    output logic                  sec_tick,
    output logic                  test_out
);
    logic      adv;
    logic      stretch;
    logic      stage_end;
    logic      sec_end;
    logic      test_wave;
    sec_kind_t kind;
    trim_set_t live;

    assign adv  = osc_en && !stop;
    assign live = '{pos: cal_pos, mag: cal_mag};

    trim_stage_div #(.PRE_DIV(PRE_DIV), .TEST_DIV(TEST_DIV)) u_stage (
        .clk(clk), .rst(rst), .adv(adv), .stretch(stretch),
        .stage_end(stage_end), .test_wave(test_wave)
    );

    trim_sec_div #(.POST_DIV(POST_DIV)) u_sec (
        .clk(clk), .rst(rst), .stage_end(stage_end), .kind(kind),
        .stretch(stretch), .sec_end(sec_end)
    );

    trim_cycle_track #(.SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_CYCLE(MIN_PER_CYCLE)) u_cycle (
        .clk(clk), .rst(rst), .sec_end(sec_end), .live(live), .kind(kind)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sec_tick <= 1'b0;
        else
            sec_tick <= sec_end;
    end

    assign test_out = test_wave;

    assert_tick_single_R10: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

    assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        stop |=> !sec_tick);

    assert_test_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(test_out));

endmodule

// File: tb/osc_trim_divider_test.sv
`timescale 1ns/1ps
module osc_trim_divider_test;

    localparam int PRE  = 8;
    localparam int POST = 4;
    localparam int SPM  = 3;
    localparam int MPC  = 64;
    localparam int TDIV = 4;
    localparam int NOM  = PRE * POST;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b0;
    logic       stop = 1'b0;
    logic [4:0] cal_mag = 5'd0;
    logic       cal_pos = 1'b0;
    logic       sec_tick;
    logic       test_out;

    osc_trim_divider #(.PRE_DIV(PRE), .POST_DIV(POST), .SEC_PER_MIN(SPM),
                       .MIN_PER_CYCLE(MPC), .TEST_DIV(TDIV)) uut (
        .clk(clk), .rst(rst), .osc_en(osc_en), .stop(stop),
        .cal_mag(cal_mag), .cal_pos(cal_pos),
        .sec_tick(sec_tick), .test_out(test_out)
    );

    always #2 clk = ~clk;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  ticks = 0, sec_mark = 0, tw_mark = 0, secs_seen = 0, cycles_done = 0;
    int  b_sec = 0, b_min = 0, b_mag = 0;
    bit  b_pos = 0, prev_tw = 0, prev_tick = 0, changed = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int s, input int m, input int mag, input bit pos);
        if (s == 0 && m < 2 * mag) return pos ? NOM - PRE : NOM + PRE / 2;
        return NOM;
    endfunction

    function automatic string tag_for(input int s, input int m, input int mag, input bit pos,
                                      input bit chg, input int cyc);
        if (s == 0 && chg) return "R7";
        if (s == 0 && m == 0 && cyc > 0) return "R6";
        if (s == 0 && m < 2 * mag) return pos ? "R3" : "R4";
        if (mag != 0) return "R5";
        return "R2";
    endfunction

    task automatic observe();
        if (sec_tick) begin
            int len;
            int ex;
            len = ticks - sec_mark;
            ex  = exp_len(b_sec, b_min, b_mag, b_pos);
            check(!prev_tick, "R10", 1, 0);
            check(len == ex, tag_for(b_sec, b_min, b_mag, b_pos, changed, cycles_done), len, ex);
            if (b_sec == 0) changed = 0;
            sec_mark = ticks;
            secs_seen++;
            if (b_sec == SPM - 1) begin
                b_sec = 0;
                b_min = (b_min + 1) % MPC;
                if (b_min == 0) cycles_done++;
                if (b_mag != int'(cal_mag) || b_pos != cal_pos) changed = 1;
                b_mag = int'(cal_mag);
                b_pos = cal_pos;
            end else begin
                b_sec++;
            end
        end
        if (test_out !== prev_tw) begin
            check(ticks - tw_mark == TDIV / 2, "R8", ticks - tw_mark, TDIV / 2);
            tw_mark = ticks;
            prev_tw = test_out;
        end
        prev_tick = sec_tick;
    endtask

    task automatic step(input bit en, input bit st);
        osc_en = en;
        stop   = st;
        @(posedge clk);
        if (en && !st) ticks++;
        @(negedge clk);
        observe();
    endtask

    task automatic do_reset(input int mag, input bit pos);
        cal_mag = 5'(mag);
        cal_pos = pos;
        osc_en  = 1'b1;
        rst     = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        osc_en = 1'b0;
        @(negedge clk);
        check(sec_tick == 1'b0, "R1", int'(sec_tick), 0);
        check(test_out == 1'b0, "R1", int'(test_out), 0);
        sec_mark = ticks; tw_mark = ticks;
        b_sec = 0; b_min = 0; b_mag = mag; b_pos = pos;
        prev_tw = 0; prev_tick = 0; changed = 0; cycles_done = 0;
    endtask

    task automatic run_secs(input int n, input int stop_pct, input bit churn);
        int target;
        target = secs_seen + n;
        while (secs_seen < target) begin
            if (churn && ($urandom % 400) == 0) begin
                cal_mag = 5'($urandom % 32);
                cal_pos = 1'($urandom % 2);
            end
            step(($urandom % 100) < 75, ($urandom % 100) < stop_pct);
        end
    endtask

    initial begin
        int seed_discard;
        seed_discard = $urandom(20240611);

        // R1, R2: reset state then nominal seconds with no correction
        do_reset(0, 0);
        run_secs(10, 0, 0);

        // R1/R7 reset-load, R3 full window N=31, R5 minutes 62/63, R6 wrap
        do_reset(31, 1);
        run_secs(200, 5, 0);

        // R7 mid-minute change, R4 lengthening across a full cycle
        run_secs(1, 0, 0);
        cal_mag = 5'd20;
        cal_pos = 1'b0;
        run_secs(200, 5, 0);

        // R4 smallest window N=1 after a fresh reset
        do_reset(1, 0);
        run_secs(12, 0, 0);

        // Random settings changing at random points
        run_secs(250, 8, 1);

        // R9: stop held with osc_en high
        begin
            bit tw0;
            int ticks_seen;
            ticks_seen = 0;
            tw0 = test_out;
            for (int i = 0; i < 40; i++) begin
                step(1'b1, 1'b1);
                if (sec_tick) ticks_seen++;
            end
            check(ticks_seen == 0, "R9", ticks_seen, 0);
            check(test_out == tw0, "R9", int'(test_out), int'(tw0));
        end
        run_secs(5, 0, 0);

        // R1: reset in mid-run clears outputs
        while (test_out != 1'b1) step(1'b1, 1'b0);
        do_reset(3, 1);
        run_secs(8, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule